// File: doc/BRIEF.md
# Future-File Operand Source Selector

This block sits beside a reorder buffer in an out-of-order core and answers one question for every source operand of the instruction being decoded: is the operand still being computed, has it been computed but not yet retired, or has it been retired? It keeps a rename table that holds one tag and one three-way state per architectural register. Beside that table it keeps a future file of speculative results and the committed architectural register file. An operand that is still being computed comes back as the producer's tag with the ready flag low. A computed operand comes from the future file, and a retired one comes from the register file. The reorder buffer is never consulted for an operand value.

A completing result always goes to the reorder buffer, which lies outside this block. It goes into the future file only when the rename entry for its destination still names its tag, so a stale result from an older writer can never overwrite the value of a younger one. Decode is in order. A decode that writes a register claims the rename entry for its own tag in the next cycle, and its own sources see the mapping that held before it. Retirement always writes the register file. It returns the register to the committed state only when the retiring tag is still the current mapping. A writeback and a lookup of the same pending register in the same cycle forward the new value straight to the operand.

Top module: `ffsel_top`

## Requirements
- R1: After reset every register is in the committed state with value zero, so every operand reads ready with data zero.
- R2: An operand whose register is pending returns ready low, with the pending tag in the low TW bits of the data and zeros above.
- R3: An operand whose register holds a completed but unretired result returns ready high with the future-file value.
- R4: An operand whose register is committed returns ready high with the register-file value.
- R5: A decode with dec_valid high makes its destination register pending under dec_tag from the next cycle on, replacing any older tag. Sources in the same cycle see the mapping that held before that decode.
- R6: A writeback whose tag differs from the rename tag of its register, or whose register is not pending, changes neither the future file nor the register's state.
- R7: A writeback whose tag matches the rename tag of a pending register stores its value in the future file and moves the register to the completed state, unless a decode renames the same register in that cycle, in which case the register stays pending under the new tag.
- R8: A retirement with cm_valid high always writes cm_value into the register file. If the register is completed and its rename tag equals cm_tag, it returns to the committed state.
- R9: A retirement whose tag does not match the rename tag leaves the register's state and tag unchanged.
- R10: A matching writeback in the same cycle as a lookup of that pending register returns ready high with the writeback value.
- R11: Each of the NSRC operand lookups is independent, and two operands that name the same register return the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode renames a destination this cycle |
| dec_src | input | NSRC*RW | Source register numbers to look up |
| dec_dst | input | RW | Destination register of the decode |
| dec_tag | input | TW | Tag given to the decoded instruction |
| wb_valid | input | 1 | A result completes this cycle |
| wb_tag | input | TW | Tag of the completing instruction |
| wb_dst | input | RW | Destination register of the completing instruction |
| wb_value | input | DW | Result value |
| cm_valid | input | 1 | An instruction retires this cycle |
| cm_tag | input | TW | Tag of the retiring instruction |
| cm_dst | input | RW | Destination register of the retiring instruction |
| cm_value | input | DW | Retired value |
| opr_ready | output | NSRC | Per operand: data is a value (1) or a tag (0) |
| opr_data | output | NSRC*DW | Per operand value, or zero-extended tag |

## Verification
On every cycle, the assertions check that a decode claims its destination, that a mismatched writeback leaves the future file alone, and that a matched one fills it. They also check that retirement always writes the register file, that a mismatched retirement keeps the mapping, and that only a pending register can yield a not-ready operand. The bench alone shows the full interplay. This covers a stale writeback after a younger rename, forwarding in the same cycle, a source and destination that coincide in one decode, and the choice of source over long random mixes of decode, writeback and retirement.

// File: rtl/ffsel_pkg.sv
package ffsel_pkg;
    // Per-register location of the latest value
    typedef enum logic [1:0] {
        RS_ARCH = 2'd0,   // retired, read register file
        RS_PEND = 2'd1,   // producer in flight, hand out tag
        RS_FUT  = 2'd2    // produced, read future file
    } rstate_e;
endpackage

// File: rtl/ffsel_table.sv
module ffsel_table
    import ffsel_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 32,
    parameter int TW   = 4,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dec_valid,
    input  logic [RW-1:0]            dec_dst,
    input  logic [TW-1:0]            dec_tag,
    input  logic                     wb_valid,
    input  logic [TW-1:0]            wb_tag,
    input  logic [RW-1:0]            wb_dst,
    input  logic [DW-1:0]            wb_value,
    input  logic                     cm_valid,
    input  logic [TW-1:0]            cm_tag,
    input  logic [RW-1:0]            cm_dst,
    input  logic [DW-1:0]            cm_value,
    output rstate_e [NREG-1:0]       st_o,
    output logic [NREG-1:0][TW-1:0]  tag_o,
    output logic [NREG-1:0][DW-1:0]  fut_o,
    output logic [NREG-1:0][DW-1:0]  arf_o
);
    typedef struct packed {
        rstate_e [NREG-1:0]          st;
        logic [NREG-1:0][TW-1:0]     tag;
        logic [NREG-1:0][DW-1:0]     fut;
        logic [NREG-1:0][DW-1:0]     arf;
    } tbl_t;

    tbl_t tbl_q, tbl_d;
    logic wb_hit, cm_hit;

    always_comb begin
        tbl_d  = tbl_q;
        wb_hit = wb_valid && (tbl_q.st[wb_dst] == RS_PEND)
                 && (tbl_q.tag[wb_dst] == wb_tag);
        cm_hit = cm_valid && (tbl_q.st[cm_dst] == RS_FUT)
                 && (tbl_q.tag[cm_dst] == cm_tag);
        // retirement: register file always, mapping only on tag match
        if (cm_valid) begin
            tbl_d.arf[cm_dst] = cm_value;
        end
        if (cm_hit) begin
            tbl_d.st[cm_dst]  = RS_ARCH;
            tbl_d.tag[cm_dst] = '0;
        end
        // completion: future file only for the newest writer
        if (wb_hit) begin
            tbl_d.fut[wb_dst] = wb_value;
            tbl_d.st[wb_dst]  = RS_FUT;
        end
        // in-order rename claims last and wins
        if (dec_valid) begin
            tbl_d.st[dec_dst]  = RS_PEND;
            tbl_d.tag[dec_dst] = dec_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign st_o  = tbl_q.st;
    assign tag_o = tbl_q.tag;
    assign fut_o = tbl_q.fut;
    assign arf_o = tbl_q.arf;

    a_r5_decode_claims: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> (tbl_q.st[$past(dec_dst)] == RS_PEND)
                      && (tbl_q.tag[$past(dec_dst)] == $past(dec_tag)));

    a_r6_stale_wb_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !((tbl_q.st[wb_dst] == RS_PEND) && (tbl_q.tag[wb_dst] == wb_tag)))
        |=> tbl_q.fut[$past(wb_dst)] == $past(tbl_q.fut[wb_dst]));

    a_r7_match_wb_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && (tbl_q.st[wb_dst] == RS_PEND) && (tbl_q.tag[wb_dst] == wb_tag)
         && !(dec_valid && (dec_dst == wb_dst)))
        |=> (tbl_q.st[$past(wb_dst)] == RS_FUT)
            && (tbl_q.fut[$past(wb_dst)] == $past(wb_value)));

    a_r8_retire_writes_arf: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |=> tbl_q.arf[$past(cm_dst)] == $past(cm_value));

    a_r9_stale_retire_keeps_map: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && (tbl_q.tag[cm_dst] != cm_tag)
         && !(dec_valid && (dec_dst == cm_dst)) && !(wb_valid && (wb_dst == cm_dst)))
        |=> (tbl_q.st[$past(cm_dst)] == $past(tbl_q.st[cm_dst]))
            && (tbl_q.tag[$past(cm_dst)] == $past(tbl_q.tag[cm_dst])));
endmodule

// File: rtl/ffsel_lookup.sv
module ffsel_lookup
    import ffsel_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 32,
    parameter int TW   = 4,
    localparam int RW  = $clog2(NREG),
    localparam int PADW = DW - TW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [RW-1:0]            src_i,
    input  rstate_e [NREG-1:0]       st_i,
    input  logic [NREG-1:0][TW-1:0]  tag_i,
    input  logic [NREG-1:0][DW-1:0]  fut_i,
    input  logic [NREG-1:0][DW-1:0]  arf_i,
    input  logic                     wb_valid,
    input  logic [TW-1:0]            wb_tag,
    input  logic [RW-1:0]            wb_dst,
    input  logic [DW-1:0]            wb_value,
    output logic                     ready_o,
    output logic [DW-1:0]            data_o
);
    logic fwd;

    always_comb begin
        fwd     = wb_valid && (wb_dst == src_i) && (wb_tag == tag_i[src_i]);
        ready_o = 1'b1;
        data_o  = arf_i[src_i];
        unique case (st_i[src_i])
            RS_PEND: begin
                if (fwd) begin
                    data_o = wb_value;
                end else begin
                    ready_o = 1'b0;
                    data_o  = {{PADW{1'b0}}, tag_i[src_i]};
                end
            end
            RS_FUT:  data_o = fut_i[src_i];
            default: data_o = arf_i[src_i];
        endcase
    end

    a_r2_wait_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (st_i[src_i] == RS_PEND) && (data_o[TW-1:0] == tag_i[src_i]));
endmodule

// File: rtl/ffsel_top.sv
module ffsel_top
    import ffsel_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 32,
    parameter int TW   = 4,
    parameter int NSRC = 2,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dec_valid,
    input  logic [NSRC-1:0][RW-1:0]   dec_src,
    input  logic [RW-1:0]             dec_dst,
    input  logic [TW-1:0]             dec_tag,
    input  logic                      wb_valid,
    input  logic [TW-1:0]             wb_tag,
    input  logic [RW-1:0]             wb_dst,
    input  logic [DW-1:0]             wb_value,
    input  logic                      cm_valid,
    input  logic [TW-1:0]             cm_tag,
    input  logic [RW-1:0]             cm_dst,
    input  logic [DW-1:0]             cm_value,
    output logic [NSRC-1:0]           opr_ready,
    output logic [NSRC-1:0][DW-1:0]   opr_data
);
    rstate_e [NREG-1:0]       st;
    logic [NREG-1:0][TW-1:0]  tag;
    logic [NREG-1:0][DW-1:0]  fut;
    logic [NREG-1:0][DW-1:0]  arf;

    ffsel_table #(.NREG(NREG), .DW(DW), .TW(TW)) u_table (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_dst(dec_dst), .dec_tag(dec_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_dst(wb_dst), .wb_value(wb_value),
        .cm_valid(cm_valid), .cm_tag(cm_tag), .cm_dst(cm_dst), .cm_value(cm_value),
        .st_o(st), .tag_o(tag), .fut_o(fut), .arf_o(arf)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        ffsel_lookup #(.NREG(NREG), .DW(DW), .TW(TW)) u_lookup (
            .clk(clk), .rst_n(rst_n), .src_i(dec_src[s]),
            .st_i(st), .tag_i(tag), .fut_i(fut), .arf_i(arf),
            .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_dst(wb_dst), .wb_value(wb_value),
            .ready_o(opr_ready[s]), .data_o(opr_data[s])
        );
    end

    // R11: equal source numbers must yield equal results
    if (NSRC > 1) begin : g_same
        a_r11_same_src_same_result: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_src[0] == dec_src[1]) |->
            (opr_ready[0] == opr_ready[1]) && (opr_data[0] == opr_data[1]));
    end
endmodule

// File: tb/ffsel_top_test.sv
module ffsel_top_test;
    localparam int NREG = 8, DW = 32, TW = 4, NSRC = 2, RW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dec_valid, wb_valid, cm_valid;
    logic [NSRC-1:0][RW-1:0] dec_src;
    logic [RW-1:0] dec_dst, wb_dst, cm_dst;
    logic [TW-1:0] dec_tag, wb_tag, cm_tag;
    logic [DW-1:0] wb_value, cm_value;
    logic [NSRC-1:0] opr_ready;
    logic [NSRC-1:0][DW-1:0] opr_data;

    int total = 0, bad = 0;
    // model state: 0 committed, 1 pending, 2 completed
    int unsigned m_st [NREG];
    logic [TW-1:0] m_tag [NREG];
    logic [DW-1:0] m_fut [NREG];
    logic [DW-1:0] m_arf [NREG];

    ffsel_top #(.NREG(NREG), .DW(DW), .TW(TW), .NSRC(NSRC)) uut (.*);

    always #10 clk = ~clk;

    function automatic logic [DW:0] expect_op(input logic [RW-1:0] r);
        if (m_st[r] == 1) begin
            if (wb_valid && wb_dst == r && wb_tag == m_tag[r]) return {1'b1, wb_value};
            return {1'b0, {(DW-TW){1'b0}}, m_tag[r]};
        end
        if (m_st[r] == 2) return {1'b1, m_fut[r]};
        return {1'b1, m_arf[r]};
    endfunction

    task automatic check_ops(input string lbl);
        for (int s = 0; s < NSRC; s++) begin
            logic [DW:0] e;
            e = expect_op(dec_src[s]);
            total++;
            if ({opr_ready[s], opr_data[s]} !== e) begin
                bad++;
                $display("FAIL %s op%0d src=%0d got rdy=%0b data=%h exp rdy=%0b data=%h",
                         lbl, s, dec_src[s], opr_ready[s], opr_data[s], e[DW], e[DW-1:0]);
            end
        end
    endtask

    task automatic model_step();
        bit wb_hit, cm_hit;
        wb_hit = wb_valid && m_st[wb_dst] == 1 && m_tag[wb_dst] == wb_tag;
        cm_hit = cm_valid && m_st[cm_dst] == 2 && m_tag[cm_dst] == cm_tag;
        if (cm_valid) m_arf[cm_dst] = cm_value;
        if (cm_hit) begin m_st[cm_dst] = 0; m_tag[cm_dst] = '0; end
        if (wb_hit) begin m_fut[wb_dst] = wb_value; m_st[wb_dst] = 2; end
        if (dec_valid) begin m_st[dec_dst] = 1; m_tag[dec_dst] = dec_tag; end
    endtask

    task automatic step(input bit dv, input int s0, input int s1, input int dd, input int dt,
                        input bit wv, input int wt, input int wd, input logic [DW-1:0] wval,
                        input bit cv, input int ct, input int cd, input logic [DW-1:0] cval,
                        input string lbl);
        @(negedge clk);
        dec_valid = dv; dec_src[0] = RW'(s0); dec_src[1] = RW'(s1);
        dec_dst = RW'(dd); dec_tag = TW'(dt);
        wb_valid = wv; wb_tag = TW'(wt); wb_dst = RW'(wd); wb_value = wval;
        cm_valid = cv; cm_tag = TW'(ct); cm_dst = RW'(cd); cm_value = cval;
        #2;
        check_ops(lbl);
        model_step();
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int r = 0; r < NREG; r++) begin
            m_st[r] = 0; m_tag[r] = '0; m_fut[r] = '0; m_arf[r] = '0;
        end
        dec_valid = 0; wb_valid = 0; cm_valid = 0; dec_src = '0;
        dec_dst = '0; dec_tag = '0; wb_tag = '0; wb_dst = '0; wb_value = '0;
        cm_tag = '0; cm_dst = '0; cm_value = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 reset state on all registers
        for (int r = 0; r < NREG; r += 2) step(0, r, r + 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
        // R5 rename r3 as tag 5; same-cycle source r3 still committed (R4)
        step(1, 3, 3, 3, 5, 0, 0, 0, 0, 0, 0, 0, 0, "R5 R4 pre-rename view");
        step(0, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 pending tag");
        // R5 younger writer of r3 as tag 6
        step(1, 3, 2, 3, 6, 0, 0, 0, 0, 0, 0, 0, 0, "R5 older tag still seen");
        step(0, 3, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 R11 younger tag");
        // R6 stale writeback from tag 5
        step(0, 2, 2, 0, 0, 1, 5, 3, 32'hdead_0005, 0, 0, 0, 0, "R6 stale wb");
        step(0, 3, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 still pending");
        // R10 forward matching writeback of tag 6
        step(0, 3, 0, 0, 0, 1, 6, 3, 32'hcafe_0006, 0, 0, 0, 0, "R10 forward");
        step(0, 3, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 R7 future value");
        // R9 stale retirement of tag 5
        step(0, 1, 1, 0, 0, 0, 0, 0, 0, 1, 5, 3, 32'hdead_0005, "R9 stale retire");
        step(0, 3, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 mapping kept");
        // R8 matching retirement
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 6, 3, 32'hcafe_0006, "R8 retire");
        step(0, 3, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 R4 committed value");
        // R7 writeback same cycle as rename of same register
        step(1, 4, 4, 4, 9, 0, 0, 0, 0, 0, 0, 0, 0, "R5 claim r4");
        step(1, 4, 4, 4, 10, 1, 9, 4, 32'h0000_0999, 0, 0, 0, 0, "R10 R7 fwd while renamed");
        step(0, 4, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 stays pending");
        // random mix, R11 independent operands
        for (int i = 0; i < 3000; i++) begin
            int wd, cd, wt, ct;
            wd = $urandom_range(NREG - 1);
            cd = $urandom_range(NREG - 1);
            wt = ($urandom_range(3) != 0) ? int'(m_tag[wd]) : $urandom_range(15);
            ct = ($urandom_range(3) != 0) ? int'(m_tag[cd]) : $urandom_range(15);
            step($urandom_range(2) == 0, $urandom_range(NREG - 1), $urandom_range(NREG - 1),
                 $urandom_range(NREG - 1), $urandom_range(15),
                 $urandom_range(1) == 1, wt, wd, $urandom,
                 $urandom_range(2) == 0, ct, cd, $urandom, "R11 random");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule